// File: doc/BRIEF.md
# Interrupt Preemption Context Stack

This block holds the interrupt context register of a core that dispatches external interrupts with nested priorities. The register carries a three-entry stack of preemption levels, the number of the interrupt being served and a flag that says the core is not inside an interrupt handler. The top level gates the core's machine external interrupt pending signal. The block drives that signal high only when some interrupt that is both pending and enabled has a priority at or above the top level.

Hardware moves the stack at three points. On trap entry the stack is pushed. On return from trap it is popped. When the next-interrupt selector is updated, the top level, the interrupt number and the flag are reloaded. Software reads and writes the whole register to save and restore it around a nested handler. The second stack entry is also driven out as the threshold for the next-interrupt selector.

Top module: `irq_ctx_stack`

## Requirements
- R1: After reset the register reads 0x0000_0800. All three levels and the interrupt number are zero, and the not-in-interrupt flag is 1.
- R2: Read layout: bits 31:28 hold the third level, bits 27:24 the second level, bits 20:16 the 5-bit top level, bit 11 the not-in-interrupt flag and bits 8:0 the interrupt number. Every other bit reads zero.
- R3: A software write with no hardware event in the same cycle stores every field from its bit positions. Data written to reserved bits is dropped, so the following read returns the write data ANDed with 0xFF1F_09FF.
- R4: A selector update sets the top level to the selected priority plus one. It also copies the selected interrupt number and no-interrupt indication into their fields.
- R5: On trap entry the third level takes the second level, and the second level takes the top level, saturated to 15 when the top level exceeds 15. The top level and the interrupt number do not change.
- R6: A trap entry whose cause is not an external interrupt sets the not-in-interrupt flag. An external-interrupt trap entry leaves the flag unchanged.
- R7: On return from trap the top level takes the second level (zero-extended), the second level takes the third level, and the third level becomes zero.
- R8: Only one event acts per cycle, ranked trap entry, return, selector update, software write. A lower-ranked event in the same cycle is dropped.
- R9: The pending output is high exactly when some interrupt i has pending and enable set and a zero-extended priority of at least the top level. With the top level at 16 or more the output stays low.
- R10: The threshold output always equals the second-level field of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_wen_i | input | 1 | Software write strobe |
| csr_wdata_i | input | 32 | Software write data |
| csr_rdata_o | output | 32 | Register read data |
| trap_enter_i | input | 1 | Trap taken pulse |
| trap_ext_i | input | 1 | Trap cause is external interrupt (valid with trap_enter_i) |
| trap_ret_i | input | 1 | Return-from-trap pulse |
| upd_i | input | 1 | Selector update strobe |
| upd_irq_i | input | 9 | Selected interrupt number |
| upd_noirq_i | input | 1 | Selector found no interrupt |
| upd_prio_i | input | 4 | Priority of the selected interrupt |
| irq_pend_i | input | NUM_IRQ | Pending array |
| irq_en_i | input | NUM_IRQ | Enable array |
| irq_prio_i | input | 4*NUM_IRQ | Priority array, interrupt i at bits 4i+3:4i |
| ext_pend_o | output | 1 | Machine external interrupt pending |
| prev_lvl_o | output | 4 | Second stack level, threshold for the selector |

## Verification
The bench builds the block with NUM_IRQ set to 12. This value is not a power of two and is small enough that sparse random pending and enable patterns often leave exactly one or no qualifying interrupt, so the pending output toggles across the priority boundary instead of staying high. With that width the directed cases can also place single interrupts at the threshold edge and just below it. The top level is pushed to 16 to reach both the saturating push and the state in which nothing can preempt.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  localparam int unsigned CSR_W  = 32;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned LVL_W  = PRIO_W + 1;
  localparam int unsigned IRQ_W  = 9;

  // bit positions; the selector and software decode these
  localparam int unsigned PPP_LSB   = 28;
  localparam int unsigned PP_LSB    = 24;
  localparam int unsigned TOP_LSB   = 16;
  localparam int unsigned NOIRQ_BIT = 11;
  localparam int unsigned IRQ_LSB   = 0;

  localparam logic [PRIO_W-1:0] PP_MAX = {PRIO_W{1'b1}};

  typedef struct packed {
    logic [PRIO_W-1:0] ppp;
    logic [PRIO_W-1:0] pp;
    logic [LVL_W-1:0]  top;
    logic              noirq;
    logic [IRQ_W-1:0]  irq;
  } ctx_t;

  function automatic logic [CSR_W-1:0] ctx_pack(ctx_t c);
    logic [CSR_W-1:0] r;
    r = '0;
    r[PPP_LSB +: PRIO_W] = c.ppp;
    r[PP_LSB  +: PRIO_W] = c.pp;
    r[TOP_LSB +: LVL_W]  = c.top;
    r[NOIRQ_BIT]         = c.noirq;
    r[IRQ_LSB +: IRQ_W]  = c.irq;
    return r;
  endfunction

  function automatic ctx_t ctx_unpack(logic [CSR_W-1:0] r);
    ctx_t c;
    c.ppp   = r[PPP_LSB +: PRIO_W];
    c.pp    = r[PP_LSB  +: PRIO_W];
    c.top   = r[TOP_LSB +: LVL_W];
    c.noirq = r[NOIRQ_BIT];
    c.irq   = r[IRQ_LSB +: IRQ_W];
    return c;
  endfunction
endpackage

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs
  import irq_ctx_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     csr_wen_i,
  input  logic [CSR_W-1:0]         csr_wdata_i,
  input  logic                     trap_enter_i,
  input  logic                     trap_ext_i,
  input  logic                     trap_ret_i,
  input  logic                     upd_i,
  input  logic [IRQ_W-1:0]         upd_irq_i,
  input  logic                     upd_noirq_i,
  input  logic [PRIO_W-1:0]        upd_prio_i,
  output ctx_t                     ctx_o
);

  ctx_t ctx_q, ctx_d, wr_ctx;
  logic [PRIO_W-1:0] push_lvl;

  assign wr_ctx   = ctx_unpack(csr_wdata_i);
  // top can hold 16+; the narrower slot saturates
  assign push_lvl = (ctx_q.top > LVL_W'(PP_MAX)) ? PP_MAX : ctx_q.top[PRIO_W-1:0];

  always_comb begin
    ctx_d = ctx_q;
    if (trap_enter_i) begin
      ctx_d.ppp = ctx_q.pp;
      ctx_d.pp  = push_lvl;
      if (!trap_ext_i) ctx_d.noirq = 1'b1;
    end else if (trap_ret_i) begin
      ctx_d.top = {1'b0, ctx_q.pp};
      ctx_d.pp  = ctx_q.ppp;
      ctx_d.ppp = '0;
    end else if (upd_i) begin
      ctx_d.top   = LVL_W'(upd_prio_i) + LVL_W'(1);
      ctx_d.irq   = upd_irq_i;
      ctx_d.noirq = upd_noirq_i;
    end else if (csr_wen_i) begin
      ctx_d = wr_ctx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_q.ppp   <= '0;
      ctx_q.pp    <= '0;
      ctx_q.top   <= '0;
      ctx_q.noirq <= 1'b1;
      ctx_q.irq   <= '0;
    end else begin
      ctx_q <= ctx_d;
    end
  end

  assign ctx_o = ctx_q;

endmodule

// File: rtl/irq_ctx_pend.sv
module irq_ctx_pend
  import irq_ctx_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32
) (
  input  logic [NUM_IRQ-1:0]        irq_pend_i,
  input  logic [NUM_IRQ-1:0]        irq_en_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio_i,
  input  logic [LVL_W-1:0]          top_i,
  output logic                      ext_pend_o
);

  logic [NUM_IRQ-1:0] qual;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_qual
    assign qual[g] = irq_pend_i[g] & irq_en_i[g] &
                     ({1'b0, irq_prio_i[g*PRIO_W +: PRIO_W]} >= top_i);
  end

  assign ext_pend_o = |qual;

endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack
  import irq_ctx_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        csr_wen_i,
  input  logic [31:0]                 csr_wdata_i,
  output logic [31:0]                 csr_rdata_o,
  input  logic                        trap_enter_i,
  input  logic                        trap_ext_i,
  input  logic                        trap_ret_i,
  input  logic                        upd_i,
  input  logic [8:0]                  upd_irq_i,
  input  logic                        upd_noirq_i,
  input  logic [3:0]                  upd_prio_i,
  input  logic [NUM_IRQ-1:0]          irq_pend_i,
  input  logic [NUM_IRQ-1:0]          irq_en_i,
  input  logic [4*NUM_IRQ-1:0]        irq_prio_i,
  output logic                        ext_pend_o,
  output logic [3:0]                  prev_lvl_o
);

  ctx_t ctx;

  irq_ctx_regs i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .csr_wen_i    (csr_wen_i),
    .csr_wdata_i  (csr_wdata_i),
    .trap_enter_i (trap_enter_i),
    .trap_ext_i   (trap_ext_i),
    .trap_ret_i   (trap_ret_i),
    .upd_i        (upd_i),
    .upd_irq_i    (upd_irq_i),
    .upd_noirq_i  (upd_noirq_i),
    .upd_prio_i   (upd_prio_i),
    .ctx_o        (ctx)
  );

  irq_ctx_pend #(.NUM_IRQ(NUM_IRQ)) i_pend (
    .irq_pend_i (irq_pend_i),
    .irq_en_i   (irq_en_i),
    .irq_prio_i (irq_prio_i),
    .top_i      (ctx.top),
    .ext_pend_o (ext_pend_o)
  );

  assign csr_rdata_o = ctx_pack(ctx);
  assign prev_lvl_o  = ctx.pp;

endmodule

// File: rtl/irq_ctx_chk.sv
module irq_ctx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        csr_wen_i,
  input logic [31:0] csr_wdata_i,
  input logic [31:0] csr_rdata_o,
  input logic        trap_enter_i,
  input logic        trap_ext_i,
  input logic        trap_ret_i,
  input logic        upd_i,
  input logic [8:0]  upd_irq_i,
  input logic [3:0]  upd_prio_i,
  input logic        ext_pend_o,
  input logic [3:0]  prev_lvl_o
);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rdata_o & 32'h00E0_F600) == 32'h0);

  // R3
  sw_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_wen_i && !trap_enter_i && !trap_ret_i && !upd_i)
      |=> csr_rdata_o == ($past(csr_wdata_i) & 32'hFF1F_09FF));

  // R4
  sel_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !trap_enter_i && !trap_ret_i)
      |=> csr_rdata_o[20:16] == ({1'b0, $past(upd_prio_i)} + 5'd1)
          && csr_rdata_o[8:0] == $past(upd_irq_i));

  // R5
  push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_enter_i |=> csr_rdata_o[31:28] == $past(csr_rdata_o[27:24])
      && csr_rdata_o[20:16] == $past(csr_rdata_o[20:16]));

  // R6
  noirq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_enter_i && !trap_ext_i) |=> csr_rdata_o[11]);

  // R7
  pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_ret_i && !trap_enter_i)
      |=> csr_rdata_o[20:16] == {1'b0, $past(csr_rdata_o[27:24])}
          && csr_rdata_o[31:28] == 4'h0);

  // R9
  no_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_rdata_o[20] |-> !ext_pend_o);

  // R10
  thresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_lvl_o == csr_rdata_o[27:24]);

endmodule

bind irq_ctx_stack irq_ctx_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .csr_wen_i    (csr_wen_i),
  .csr_wdata_i  (csr_wdata_i),
  .csr_rdata_o  (csr_rdata_o),
  .trap_enter_i (trap_enter_i),
  .trap_ext_i   (trap_ext_i),
  .trap_ret_i   (trap_ret_i),
  .upd_i        (upd_i),
  .upd_irq_i    (upd_irq_i),
  .upd_prio_i   (upd_prio_i),
  .ext_pend_o   (ext_pend_o),
  .prev_lvl_o   (prev_lvl_o)
);

// File: tb/test_irq_ctx_stack.sv
module test_irq_ctx_stack;
  localparam int N = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wen = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          t_ent = 1'b0, t_ext = 1'b0, t_ret = 1'b0;
  logic          upd = 1'b0, upd_noirq = 1'b0;
  logic [8:0]    upd_irq = '0;
  logic [3:0]    upd_prio = '0;
  logic [N-1:0]  pend = '0, en = '0;
  logic [4*N-1:0] prio = '0;
  logic          ext_pend;
  logic [3:0]    prev_lvl;

  int n_chk = 0, n_fail = 0;
  logic [31:0] model;
  logic done = 1'b0;

  always #2 clk = ~clk;

  irq_ctx_stack #(.NUM_IRQ(N)) i_irq_ctx_stack (
    .clk_i(clk), .rst_ni(rst_n), .csr_wen_i(wen), .csr_wdata_i(wdata),
    .csr_rdata_o(rdata), .trap_enter_i(t_ent), .trap_ext_i(t_ext),
    .trap_ret_i(t_ret), .upd_i(upd), .upd_irq_i(upd_irq),
    .upd_noirq_i(upd_noirq), .upd_prio_i(upd_prio), .irq_pend_i(pend),
    .irq_en_i(en), .irq_prio_i(prio), .ext_pend_o(ext_pend),
    .prev_lvl_o(prev_lvl)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_img(logic [31:0] c);
    logic [31:0] n = c;
    if (t_ent) begin
      n[31:28] = c[27:24];
      n[27:24] = (c[20:16] > 5'd15) ? 4'hF : c[19:16];
      if (!t_ext) n[11] = 1'b1;
    end else if (t_ret) begin
      n[20:16] = {1'b0, c[27:24]};
      n[27:24] = c[31:28];
      n[31:28] = 4'h0;
    end else if (upd) begin
      n[20:16] = {1'b0, upd_prio} + 5'd1;
      n[11]    = upd_noirq;
      n[8:0]   = upd_irq;
    end else if (wen) begin
      n = wdata & 32'hFF1F_09FF;
    end
    return n;
  endfunction

  function automatic logic exp_pend(logic [4:0] top);
    for (int i = 0; i < N; i++)
      if (pend[i] && en[i] && ({1'b0, prio[4*i +: 4]} >= top)) return 1'b1;
    return 1'b0;
  endfunction

  // one clock: apply driven inputs, check state after the edge
  task automatic tick(string tag);
    string t;
    t = tag;
    if (t == "") t = t_ent ? (t_ext ? "R5" : "R6") : t_ret ? "R7" : upd ? "R4" : wen ? "R3" : "R2";
    model = next_img(model);
    @(posedge clk); #1;
    check(t, rdata, model);
    check("R9", {31'b0, ext_pend}, {31'b0, exp_pend(model[20:16])});
    check("R10", {28'b0, prev_lvl}, {28'b0, model[27:24]});
    @(negedge clk);
    wen = 0; t_ent = 0; t_ret = 0; t_ext = 0; upd = 0;
  endtask

  task automatic set_irq(int i, logic p, logic e, logic [3:0] pr);
    pend[i] = p; en[i] = e; prio[4*i +: 4] = pr;
  endtask

  initial begin
    #(4*150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h1C7A);
    model = 32'h0000_0800;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", rdata, 32'h0000_0800);
    check("R1", {28'b0, prev_lvl}, 32'h0);
    check("R1", {31'b0, ext_pend}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reserved bits dropped
    wen = 1; wdata = 32'hFFFF_FFFF; tick("R3");
    check("R2", rdata, 32'hFF1F_09FF);
    // R9 threshold boundary with top = 5
    wen = 1; wdata = 32'h0005_0000; tick("R3");
    set_irq(3, 1, 1, 4'd4); #1;
    check("R9", {31'b0, ext_pend}, 32'h0);
    set_irq(3, 1, 1, 4'd5); #1;
    check("R9", {31'b0, ext_pend}, 32'h1);
    set_irq(3, 1, 0, 4'd5); #1;
    check("R9", {31'b0, ext_pend}, 32'h0);
    // R4 update to 15 -> top 16, nothing preempts
    for (int i = 0; i < N; i++) set_irq(i, 1, 1, 4'hF);
    upd = 1; upd_prio = 4'hF; upd_irq = 9'd7; upd_noirq = 0; tick("R4");
    check("R9", {31'b0, ext_pend}, 32'h0);
    // R5 saturating push from 16
    t_ent = 1; t_ext = 1; tick("R5");
    check("R5", {28'b0, prev_lvl}, 32'hF);
    // R8 entry beats return; update beats write
    t_ent = 1; t_ret = 1; t_ext = 0; tick("R8");
    upd = 1; upd_prio = 4'd2; upd_irq = 9'd300; wen = 1; wdata = 32'h0; tick("R8");
    wen = 1; t_ret = 1; wdata = 32'hFFFF_FFFF; tick("R8");
    // R7 pops
    t_ret = 1; tick("R7");
    t_ret = 1; tick("R7");

    pend = '0; en = '0;
    for (int k = 0; k < 600; k++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0) t_ent = 1;
      if (sel == 1 || sel == 2) t_ret = 1;
      if (sel == 3 || sel == 4) upd = 1;
      if (sel == 5 || $urandom_range(0, 5) == 0) wen = 1;
      if (sel == 6) begin t_ent = 1; t_ret = 1; upd = 1; end
      t_ext = $urandom_range(0, 1) != 0;
      upd_noirq = $urandom_range(0, 3) == 0;
      upd_irq = 9'($urandom);
      upd_prio = 4'($urandom);
      wdata = $urandom;
      if ($urandom_range(0, 3) == 0) begin
        pend = N'($urandom) & N'($urandom);
        en = N'($urandom) & N'($urandom);
        for (int i = 0; i < N; i++) prio[4*i +: 4] = 4'($urandom);
      end
      tick("");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule